// File: doc/BRIEF.md
# Strobed GPIO Register Target with Routing Table

This block sits on the far end of an 8-bit parallel control bus that a host drives slowly by toggling levels. Bit 7 of the bus is a strobe level. The block samples bits 6:0 when it sees bit 7 rise. Bit 6 of that byte decides its meaning. With bit 6 set, the low six bits pick one of 64 six-bit registers. With bit 6 clear, the low six bits are a value for the register picked last. The host steps through four levels for each write: index, index with strobe, value, value with strobe. The contents of the picked register appear on a byte-wide read port.

Four of the registers give indirect access to a table that links destinations to sources. Each ID has 8 bits: 3 high bits and 5 low bits. Index 0x30 holds the destination high part and index 0x31 the destination low part. Index 0x32 holds the source high part and index 0x33 the source low part. Writing index 0x33 stores the full source in the entry of the chosen destination. Reading index 0x32 or 0x33 returns the parts of the source currently linked to the chosen destination. A separate group of sense inputs raises a sticky interrupt whenever any of them changes.

All bus and sense inputs pass through a synchronizer. A two-state phase machine tracks the protocol. The state PH_WAIT_ADDR waits for an index byte. It moves to PH_WAIT_VAL (transition "select") on a strobed index byte. In PH_WAIT_VAL, a strobed value byte writes the register and returns to PH_WAIT_ADDR (transition "commit"). A strobed index byte in PH_WAIT_VAL picks a new register and stays in PH_WAIT_VAL (transition "reselect"). A strobed value byte in PH_WAIT_ADDR leaves the state unchanged (transition "drop").

Top module: `gio_regport`

## Requirements
- R1: After reset, every register, every table entry and the interrupt are zero. The read port shows 0 for any register, and reading the source of any destination gives 0.
- R2: A byte is taken only when bit 7 rises. A change of bits 6:0 while bit 7 stays high or stays low has no effect.
- R3: A strobed byte with bit 6 set picks the register whose index is bits 5:0. After that, the read port shows that register's contents.
- R4: A strobed byte with bit 6 clear, taken after a register was picked, stores bits 5:0 in that register.
- R5: A strobed value byte is dropped when no register pick is pending. This is the case after reset and after each write has taken its value.
- R6: The read port carries the six-bit contents on bits 5:0, and bits 7:6 always read 0.
- R7: Writing index 0x33 links a source to a destination. The source is {bits 2:0 of index 0x32, bits 4:0 of the written value}. The destination is {bits 2:0 of index 0x30, bits 4:0 of index 0x31}. Higher bits are ignored when forming the IDs.
- R8: With index 0x32 picked, the read port shows the 3-bit high part of the source linked to the chosen destination. With index 0x33 picked, it shows the 5-bit low part.
- R9: A destination holds one source, and a later link to it replaces the earlier one. One source may be linked to many destinations at once.
- R10: A change of any sense input sets the interrupt. It stays set until the acknowledge input is high while no new change occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 8 | Host bus: bit 7 strobe, bits 6:0 index or value |
| rd_byte | output | 8 | Contents of the picked register |
| sense_in | input | SENSE_W (7) | Sense inputs watched for change |
| irq_ack | input | 1 | Clears the interrupt |
| irq | output | 1 | Sticky change interrupt |

## Verification
Every bus and sense input takes two synchronizer flops and one edge-detect flop. So a register write, a new pick, a table link and a read-port update are all due on the third clock edge after the strobe rises. A sense change sets the interrupt on its third edge. An acknowledge clears it on the first edge. The bench drives inputs on falling edges and holds each bus level for ten cycles, well past that three-edge latency. It samples outputs only on a falling edge at the end of the hold. Ignored-stimulus checks read the affected register back through the read port before any further strobe.

// File: rtl/gio_pkg.sv
package gio_pkg;
    localparam int BUS_W    = 8;
    localparam int IDX_W    = 6;
    localparam int VAL_W    = 6;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int ID_HI_W  = 3;
    localparam int ID_LO_W  = 5;
    localparam int ID_W     = ID_HI_W + ID_LO_W;

    localparam logic [IDX_W-1:0] DST_HI_IDX = 6'h30;
    localparam logic [IDX_W-1:0] DST_LO_IDX = 6'h31;
    localparam logic [IDX_W-1:0] SRC_HI_IDX = 6'h32;
    localparam logic [IDX_W-1:0] SRC_LO_IDX = 6'h33;

    typedef enum logic [0:0] {
        PH_WAIT_ADDR = 1'b0,
        PH_WAIT_VAL  = 1'b1
    } phase_t;
endpackage

// File: rtl/gio_sync.sv
module gio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else begin
                    if (s == 0) chain[s] <= d;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_prev <= '0;
        else        q_prev <= chain[STAGES-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gio_phase_fsm.sv
module gio_phase_fsm
    import gio_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   strobe_rise,
    input  logic   is_index,
    output logic   sel_load,
    output logic   wr_en,
    output phase_t phase
);
    phase_t phase_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_WAIT_ADDR;
        else        phase <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_WAIT_ADDR: if (strobe_rise && is_index) phase_nxt = PH_WAIT_VAL;
            PH_WAIT_VAL:  if (strobe_rise && !is_index) phase_nxt = PH_WAIT_ADDR;
            default:      phase_nxt = PH_WAIT_ADDR;
        endcase
    end

    always_comb begin
        sel_load = 1'b0;
        wr_en    = 1'b0;
        unique case (phase)
            PH_WAIT_ADDR: sel_load = strobe_rise && is_index;
            PH_WAIT_VAL: begin
                sel_load = strobe_rise && is_index;
                wr_en    = strobe_rise && !is_index;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gio_route_table.sv
module gio_route_table #(
    parameter int HI_W = 3,
    parameter int LO_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [HI_W+LO_W-1:0] wr_dst,
    input  logic [HI_W+LO_W-1:0] wr_src,
    input  logic [HI_W+LO_W-1:0] rd_dst,
    output logic [HI_W+LO_W-1:0] rd_src
);
    localparam int ID_W    = HI_W + LO_W;
    localparam int ENTRIES = 1 << ID_W;

    logic [ID_W-1:0] link_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) link_q[i] <= '0;
        end else if (we) begin
            link_q[wr_dst] <= wr_src;
        end
    end

    assign rd_src = link_q[rd_dst];
endmodule

// File: rtl/gio_regport.sv
module gio_regport
    import gio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SENSE_W     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   gpio_in,
    output logic [BUS_W-1:0]   rd_byte,
    input  logic [SENSE_W-1:0] sense_in,
    input  logic               irq_ack,
    output logic               irq
);
    localparam int STB_BIT = BUS_W - 1;
    localparam int SEL_BIT = BUS_W - 2;

    logic [BUS_W-1:0]   bus_q, bus_prev;
    logic [SENSE_W-1:0] sense_q, sense_prev;
    logic               strobe_rise, sense_chg;
    logic               sel_load, wr_en, commit;
    phase_t             phase;

    logic [IDX_W-1:0]   sel_q;
    logic [VAL_W-1:0]   regs [NUM_REGS];
    logic [ID_W-1:0]    dst_id, src_wr, src_rd;
    logic [VAL_W-1:0]   rd_val;

    gio_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) bus_sync_i (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(bus_q), .q_prev(bus_prev)
    );

    gio_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) sense_sync_i (
        .clk(clk), .rst_n(rst_n), .d(sense_in), .q(sense_q), .q_prev(sense_prev)
    );

    assign strobe_rise = bus_q[STB_BIT] & ~bus_prev[STB_BIT];
    assign sense_chg   = |(sense_q ^ sense_prev);

    gio_phase_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise),
        .is_index(bus_q[SEL_BIT]), .sel_load(sel_load), .wr_en(wr_en),
        .phase(phase)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel_q <= '0;
        else if (sel_load) sel_q <= bus_q[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[sel_q] <= bus_q[VAL_W-1:0];
        end
    end

    assign commit = wr_en && (sel_q == SRC_LO_IDX);
    assign dst_id = {regs[DST_HI_IDX][ID_HI_W-1:0], regs[DST_LO_IDX][ID_LO_W-1:0]};
    assign src_wr = {regs[SRC_HI_IDX][ID_HI_W-1:0], bus_q[ID_LO_W-1:0]};

    gio_route_table #(.HI_W(ID_HI_W), .LO_W(ID_LO_W)) route_i (
        .clk(clk), .rst_n(rst_n), .we(commit), .wr_dst(dst_id),
        .wr_src(src_wr), .rd_dst(dst_id), .rd_src(src_rd)
    );

    always_comb begin
        if (sel_q == SRC_HI_IDX)
            rd_val = {{(VAL_W-ID_HI_W){1'b0}}, src_rd[ID_W-1:ID_LO_W]};
        else if (sel_q == SRC_LO_IDX)
            rd_val = {{(VAL_W-ID_LO_W){1'b0}}, src_rd[ID_LO_W-1:0]};
        else
            rd_val = regs[sel_q];
    end

    assign rd_byte = {{(BUS_W-VAL_W){1'b0}}, rd_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq <= 1'b0;
        else if (sense_chg) irq <= 1'b1;
        else if (irq_ack)   irq <= 1'b0;
    end
endmodule

// File: rtl/gio_regport_chk.sv
module gio_regport_chk
    import gio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_rise,
    input logic             wr_en,
    input phase_t           phase,
    input logic [BUS_W-1:0] rd_byte,
    input logic             irq,
    input logic             irq_ack,
    input logic             sense_chg
);
    p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_rise |=> $stable(rd_byte));

    p_write_rearms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (phase == PH_WAIT_ADDR));

    p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sense_chg |=> irq);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !sense_chg) |=> !irq);
endmodule

bind gio_regport gio_regport_chk chk_i (
    .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise), .wr_en(wr_en),
    .phase(phase), .rd_byte(rd_byte), .irq(irq), .irq_ack(irq_ack),
    .sense_chg(sense_chg)
);

// File: tb/gio_regport_tb_top.sv
module gio_regport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] gpio_in = 8'h00;
    logic [7:0] rd_byte;
    logic [6:0] sense_in = 7'h00;
    logic       irq_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gio_regport dut_i (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .rd_byte(rd_byte),
        .sense_in(sense_in), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        gpio_in = b;
        repeat (10) @(negedge clk);
    endtask

    task automatic pick(input logic [5:0] idx);
        put({2'b01, idx});
        put({2'b11, idx});
    endtask

    task automatic value(input logic [5:0] v);
        put({2'b00, v});
        put({2'b10, v});
    endtask

    task automatic wr(input logic [5:0] idx, input logic [5:0] v);
        pick(idx);
        value(v);
    endtask

    task automatic read_chk(input string req, input logic [5:0] idx, input logic [7:0] exp);
        pick(idx);
        check(req, rd_byte, exp);
    endtask

    task automatic link(input logic [5:0] dhi, input logic [5:0] dlo,
                        input logic [5:0] shi, input logic [5:0] slo);
        wr(6'h30, dhi);
        wr(6'h31, dlo);
        wr(6'h32, shi);
        wr(6'h33, slo);
    endtask

    task automatic t_reset;
        check("R1 rd after reset", rd_byte, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        // R5: value with no pick pending after reset is dropped
        value(6'h15);
        check("R5 drop after reset", rd_byte, 8'h00);
        read_chk("R1 reg 9 zero", 6'h09, 8'h00);
        wr(6'h30, 6'h07);
        wr(6'h31, 6'h1F);
        read_chk("R1 unlinked src hi", 6'h32, 8'h00);
        read_chk("R1 unlinked src lo", 6'h33, 8'h00);
    endtask

    task automatic t_basic;
        wr(6'h05, 6'h2A);
        check("R3 R4 rd after write", rd_byte, 8'h2A);
        wr(6'h3F, 6'h3F);
        check("R6 upper bits zero", rd_byte, 8'h3F);
        wr(6'h00, 6'h01);
        read_chk("R4 reg 5 kept", 6'h05, 8'h2A);
        read_chk("R3 reg 63", 6'h3F, 8'h3F);
        read_chk("R3 reg 0", 6'h00, 8'h01);
    endtask

    task automatic t_strobe;
        pick(6'h07);
        value(6'h0C);
        check("R4 reg 7", rd_byte, 8'h0C);
        // R2: strobe held high, low bits change
        put(8'h80 | 8'h15);
        put(8'h80 | 8'h4B);
        check("R2 no capture while high", rd_byte, 8'h0C);
        put(8'h4B);
        put(8'h11);
        check("R2 no capture while low", rd_byte, 8'h0C);
        // R5: value after a completed write dropped
        put(8'h91);
        check("R5 value after write dropped", rd_byte, 8'h0C);
        // reselect then value
        pick(6'h08);
        pick(6'h07);
        value(6'h21);
        check("R4 reselect write", rd_byte, 8'h21);
        read_chk("R4 reg 8 untouched", 6'h08, 8'h00);
    endtask

    task automatic t_route;
        link(6'h03, 6'h0A, 6'h05, 6'h11);
        read_chk("R8 src hi", 6'h32, 8'h05);
        read_chk("R8 src lo", 6'h33, 8'h11);
        link(6'h01, 6'h02, 6'h05, 6'h11);
        wr(6'h30, 6'h03);
        wr(6'h31, 6'h0A);
        read_chk("R9 shared src hi", 6'h32, 8'h05);
        read_chk("R9 shared src lo", 6'h33, 8'h11);
        link(6'h03, 6'h0A, 6'h02, 6'h04);
        read_chk("R9 replaced hi", 6'h32, 8'h02);
        read_chk("R9 replaced lo", 6'h33, 8'h04);
        wr(6'h30, 6'h01);
        wr(6'h31, 6'h02);
        read_chk("R9 other dst kept", 6'h33, 8'h11);
        wr(6'h30, 6'h3B);
        wr(6'h31, 6'h2A);
        read_chk("R7 masked dst hi", 6'h32, 8'h02);
        read_chk("R7 masked dst lo", 6'h33, 8'h04);
        link(6'h00, 6'h00, 6'h3E, 6'h3F);
        read_chk("R7 masked src hi", 6'h32, 8'h06);
        read_chk("R7 masked src lo", 6'h33, 8'h1F);
    endtask

    task automatic t_irq;
        @(negedge clk);
        sense_in = 7'h04;
        repeat (5) @(negedge clk);
        check("R10 irq set", {7'b0, irq}, 8'h01);
        sense_in = 7'h00;
        repeat (20) @(negedge clk);
        check("R10 irq held", {7'b0, irq}, 8'h01);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R10 irq cleared", {7'b0, irq}, 8'h00);
        repeat (5) @(negedge clk);
        check("R10 irq stays clear", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_strobe();
        t_route();
        t_irq();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule